// File: doc/BRIEF.md
# Load-Store Byte Alignment Unit

This unit sits between a processor core and a 32-bit, word-addressed, little-endian data memory. For each memory operation it forms the effective byte address from a base register value and a signed 16-bit displacement. It splits that address into a word address and a lane number, and it drives per-lane byte enables. For stores it replicates the source data across the lanes. For loads it turns the returned memory word into the register value. That value is sign or zero extended for byte and halfword loads, passed through for word loads, and merged with the old register contents for the two partial-word loads that handle unaligned data.

A request is presented for one cycle on the request port. In the next cycle the unit drives the memory request, or raises the address-error flag instead. The memory returns read data in that same cycle, and the load result appears one cycle later. Requests may be issued back to back, one per cycle. Halfword and word accesses that are not naturally aligned are refused: no memory request is made, no lane is enabled and no load result is produced.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective address is `req_base_i` plus the sign-extended `req_offset_i`. One cycle after an accepted request, `mem_addr_o` carries that address with its two low bits dropped, and lane k of the data bus holds the byte whose address ends in k.
- R2: Byte loads (opcode 6'b100000 signed, 6'b100100 unsigned) return the addressed byte in bits 7:0, with bits 31:8 copied from its bit 7 (signed) or zero (unsigned).
- R3: Halfword loads (6'b100001 signed, 6'b100101 unsigned) return the two bytes at the addressed lane and the lane above it in bits 15:0, extended by sign or by zero.
- R4: A word load (6'b100011) returns the full memory word unchanged.
- R5: A halfword access (6'b100001, 6'b100101, 6'b101001) at an odd lane, or a word access (6'b100011, 6'b101011) at a nonzero lane, drives `addr_err_o` high in the following cycle. In that cycle `mem_req_o` is low and every byte enable is low, and no load result follows.
- R6: The left partial load (6'b100010) at lane a places memory lanes a down to 0 into register bytes 3 down to 3-a. All lower register bytes keep the value of `req_old_rd_i`. It never faults.
- R7: The right partial load (6'b100110) at lane a places memory lanes a up to 3 into register bytes 0 up to 3-a. All higher register bytes keep the value of `req_old_rd_i`. It never faults.
- R8: A byte store (6'b101000) asserts only the enable for the addressed lane and drives the low byte of `req_store_data_i` on all four lanes.
- R9: A halfword store (6'b101001) asserts the enables for the addressed lane and the lane above it, and drives the low 16 bits of the store data on both halves of the bus.
- R10: A word store (6'b101011) asserts all four enables and drives the store data unchanged. `mem_we_o` is high for all three store opcodes.
- R11: Loads assert the enables of exactly the lanes they read: a byte load one lane, a halfword load two lanes, a word load four lanes, the left partial load lanes 0 to a, and the right partial load lanes a to 3.
- R12: An opcode outside the ten listed above, or a cycle without `req_valid_i`, produces no memory request, no address error and no load result.
- R13: After reset all outputs are low. `ld_valid_o` is high exactly one cycle after each load's memory request, with `ld_data_o` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_opcode_i | input | 6 | Memory operation code |
| req_base_i | input | ADDR_W | Base register value |
| req_offset_i | input | OFFS_W | Signed displacement |
| req_store_data_i | input | 32 | Source register for stores |
| req_old_rd_i | input | 32 | Current destination register value, used by partial loads |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W-2 | Word address |
| mem_be_o | output | 4 | Per-lane byte enables |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| mem_rdata_i | input | 32 | Read word returned in the request cycle |
| addr_err_o | output | 1 | Misaligned access refused |
| ld_valid_o | output | 1 | Load result present |
| ld_data_o | output | 32 | Extended or merged load result |

## Verification
The bench builds the unit with ADDR_W at 32 and OFFS_W at 16. With these values a full-width base plus a negative displacement carries across the upper address bits. This makes the sign extension of the offset visible on `mem_addr_o` and in which memory word is read. Every opcode is issued at all four lanes, so each alignment fault, each extension polarity and every left and right merge width from one to four bytes is reached. The requests run back to back, so the pipeline overlap between one request's memory cycle and the previous load's result is covered as well.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / 8;
    localparam int LANE_IDX_W = $clog2(LANES);
    localparam int OPC_W      = 6;

    localparam logic [OPC_W-1:0] OPC_LD_B   = 6'b100000;
    localparam logic [OPC_W-1:0] OPC_LD_H   = 6'b100001;
    localparam logic [OPC_W-1:0] OPC_LD_L   = 6'b100010;
    localparam logic [OPC_W-1:0] OPC_LD_W   = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_LD_BU  = 6'b100100;
    localparam logic [OPC_W-1:0] OPC_LD_HU  = 6'b100101;
    localparam logic [OPC_W-1:0] OPC_LD_R   = 6'b100110;
    localparam logic [OPC_W-1:0] OPC_ST_B   = 6'b101000;
    localparam logic [OPC_W-1:0] OPC_ST_H   = 6'b101001;
    localparam logic [OPC_W-1:0] OPC_ST_W   = 6'b101011;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_BYTE,
        ACC_HALF,
        ACC_WORD,
        ACC_LEFT,
        ACC_RIGHT
    } acc_kind_e;

    typedef struct packed {
        logic      known;
        logic      store;
        logic      sext;
        acc_kind_e kind;
    } acc_dec_t;

    function automatic acc_dec_t decode_opcode(input logic [OPC_W-1:0] opc);
        acc_dec_t d;
        d.known = 1'b1;
        d.store = 1'b0;
        d.sext  = 1'b0;
        d.kind  = ACC_NONE;
        case (opc)
            OPC_LD_B:  begin d.kind = ACC_BYTE;  d.sext = 1'b1; end
            OPC_LD_BU: begin d.kind = ACC_BYTE;  end
            OPC_LD_H:  begin d.kind = ACC_HALF;  d.sext = 1'b1; end
            OPC_LD_HU: begin d.kind = ACC_HALF;  end
            OPC_LD_W:  begin d.kind = ACC_WORD;  end
            OPC_LD_L:  begin d.kind = ACC_LEFT;  end
            OPC_LD_R:  begin d.kind = ACC_RIGHT; end
            OPC_ST_B:  begin d.kind = ACC_BYTE;  d.store = 1'b1; end
            OPC_ST_H:  begin d.kind = ACC_HALF;  d.store = 1'b1; end
            OPC_ST_W:  begin d.kind = ACC_WORD;  d.store = 1'b1; end
            default:   begin d.known = 1'b0; end
        endcase
        return d;
    endfunction

    // Natural alignment rule per access size.
    function automatic logic is_misaligned(input acc_kind_e k,
                                           input logic [LANE_IDX_W-1:0] lane);
        case (k)
            ACC_HALF: return lane[0];
            ACC_WORD: return |lane;
            default:  return 1'b0;
        endcase
    endfunction

    // Lanes touched by an access of kind k starting at lane.
    function automatic logic [LANES-1:0] lane_span(input acc_kind_e k,
                                                   input logic [LANE_IDX_W-1:0] lane);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            case (k)
                ACC_BYTE:  m[i] = (i == int'(lane));
                ACC_HALF:  m[i] = (i == int'(lane)) || (i == int'(lane) + 1);
                ACC_WORD:  m[i] = 1'b1;
                ACC_LEFT:  m[i] = (i <= int'(lane));
                ACC_RIGHT: m[i] = (i >= int'(lane));
                default:   m[i] = 1'b0;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 16
) (
    input  logic [ADDR_W-1:0]            base_i,
    input  logic [OFFS_W-1:0]            offs_i,
    output logic [ADDR_W-LANE_IDX_W-1:0] word_addr_o,
    output logic [LANE_IDX_W-1:0]        lane_o
);
    localparam int EXT_W = ADDR_W - OFFS_W;

    logic [ADDR_W-1:0] offs_ext;
    logic [ADDR_W-1:0] eff_addr;

    assign offs_ext    = {{EXT_W{offs_i[OFFS_W-1]}}, offs_i};
    assign eff_addr    = base_i + offs_ext;
    assign word_addr_o = eff_addr[ADDR_W-1:LANE_IDX_W];
    assign lane_o      = eff_addr[LANE_IDX_W-1:0];
endmodule

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
    import lsu_align_pkg::*;
(
    input  acc_dec_t              dec_i,
    input  logic [LANE_IDX_W-1:0] lane_i,
    input  logic                  fault_i,
    input  logic [WORD_W-1:0]     store_data_i,
    output logic [LANES-1:0]      be_o,
    output logic [WORD_W-1:0]     wdata_o
);
    logic [LANES-1:0] span;
    logic             allow;

    assign span  = lane_span(dec_i.kind, lane_i);
    assign allow = dec_i.known && !fault_i;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] lane_byte;

        assign be_o[i] = span[i] && allow;

        always_comb begin
            lane_byte = 8'h00;
            if (dec_i.store) begin
                case (dec_i.kind)
                    ACC_BYTE: lane_byte = store_data_i[7:0];
                    ACC_HALF: lane_byte = store_data_i[8*(i%2) +: 8];
                    ACC_WORD: lane_byte = store_data_i[8*i +: 8];
                    default:  lane_byte = 8'h00;
                endcase
            end
        end

        assign wdata_o[8*i +: 8] = lane_byte;
    end
endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge
    import lsu_align_pkg::*;
(
    input  acc_dec_t              dec_i,
    input  logic [LANE_IDX_W-1:0] lane_i,
    input  logic [WORD_W-1:0]     rdata_i,
    input  logic [WORD_W-1:0]     old_i,
    output logic [WORD_W-1:0]     result_o
);
    localparam logic [LANE_IDX_W-1:0] TOP_LANE = LANE_IDX_W'(LANES - 1);

    logic [LANE_IDX_W-1:0] rev_lane;
    logic [WORD_W-1:0]     down_word;
    logic [WORD_W-1:0]     up_word;
    logic [WORD_W-1:0]     left_word;
    logic [WORD_W-1:0]     right_word;

    assign rev_lane  = TOP_LANE - lane_i;
    assign down_word = rdata_i >> {lane_i, 3'b000};
    assign up_word   = rdata_i << {rev_lane, 3'b000};

    for (genvar i = 0; i < LANES; i++) begin : g_merge
        logic take_left;
        logic take_right;
        assign take_left  = (i >= int'(rev_lane));
        assign take_right = (i <= int'(rev_lane));
        assign left_word[8*i +: 8]  = take_left  ? up_word[8*i +: 8]   : old_i[8*i +: 8];
        assign right_word[8*i +: 8] = take_right ? down_word[8*i +: 8] : old_i[8*i +: 8];
    end

    always_comb begin
        case (dec_i.kind)
            ACC_BYTE:  result_o = {{(WORD_W-8){dec_i.sext & down_word[7]}}, down_word[7:0]};
            ACC_HALF:  result_o = {{(WORD_W-16){dec_i.sext & down_word[15]}}, down_word[15:0]};
            ACC_WORD:  result_o = rdata_i;
            ACC_LEFT:  result_o = left_word;
            ACC_RIGHT: result_o = right_word;
            default:   result_o = '0;
        endcase
    end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid_i,
    input  logic [OPC_W-1:0]             req_opcode_i,
    input  logic [ADDR_W-1:0]            req_base_i,
    input  logic [OFFS_W-1:0]            req_offset_i,
    input  logic [WORD_W-1:0]            req_store_data_i,
    input  logic [WORD_W-1:0]            req_old_rd_i,
    output logic                         mem_req_o,
    output logic                         mem_we_o,
    output logic [ADDR_W-LANE_IDX_W-1:0] mem_addr_o,
    output logic [LANES-1:0]             mem_be_o,
    output logic [WORD_W-1:0]            mem_wdata_o,
    input  logic [WORD_W-1:0]            mem_rdata_i,
    output logic                         addr_err_o,
    output logic                         ld_valid_o,
    output logic [WORD_W-1:0]            ld_data_o
);
    localparam int WADDR_W = ADDR_W - LANE_IDX_W;

    // Request-cycle decode
    acc_dec_t              in_dec;
    logic [WADDR_W-1:0]    in_waddr;
    logic [LANE_IDX_W-1:0] in_lane;
    logic                  in_fault;
    logic [LANES-1:0]      in_be;
    logic [WORD_W-1:0]     in_wdata;

    assign in_dec   = decode_opcode(req_opcode_i);
    assign in_fault = is_misaligned(in_dec.kind, in_lane);

    lsu_addr_gen #(
        .ADDR_W (ADDR_W),
        .OFFS_W (OFFS_W)
    ) addr_gen_i (
        .base_i      (req_base_i),
        .offs_i      (req_offset_i),
        .word_addr_o (in_waddr),
        .lane_o      (in_lane)
    );

    lsu_lane_ctrl lane_ctrl_i (
        .dec_i        (in_dec),
        .lane_i       (in_lane),
        .fault_i      (in_fault),
        .store_data_i (req_store_data_i),
        .be_o         (in_be),
        .wdata_o      (in_wdata)
    );

    // Memory-cycle stage
    logic                  s1_live;
    logic                  s1_fault;
    acc_dec_t              s1_dec;
    logic [LANE_IDX_W-1:0] s1_lane;
    logic [WADDR_W-1:0]    s1_waddr;
    logic [LANES-1:0]      s1_be;
    logic [WORD_W-1:0]     s1_wdata;
    logic [WORD_W-1:0]     s1_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_live  <= 1'b0;
            s1_fault <= 1'b0;
            s1_dec   <= '{known: 1'b0, store: 1'b0, sext: 1'b0, kind: ACC_NONE};
            s1_lane  <= '0;
            s1_waddr <= '0;
            s1_be    <= '0;
            s1_wdata <= '0;
            s1_old   <= '0;
        end else begin
            s1_live  <= req_valid_i && in_dec.known;
            s1_fault <= in_fault;
            s1_dec   <= in_dec;
            s1_lane  <= in_lane;
            s1_waddr <= in_waddr;
            s1_be    <= req_valid_i ? in_be : '0;
            s1_wdata <= in_wdata;
            s1_old   <= req_old_rd_i;
        end
    end

    logic s1_go;
    assign s1_go       = s1_live && !s1_fault;
    assign mem_req_o   = s1_go;
    assign mem_we_o    = s1_go && s1_dec.store;
    assign mem_addr_o  = s1_waddr;
    assign mem_be_o    = s1_be;
    assign mem_wdata_o = s1_wdata;
    assign addr_err_o  = s1_live && s1_fault;

    // Load result stage
    logic [WORD_W-1:0] merged;

    lsu_load_merge load_merge_i (
        .dec_i    (s1_dec),
        .lane_i   (s1_lane),
        .rdata_i  (mem_rdata_i),
        .old_i    (s1_old),
        .result_o (merged)
    );

    logic              s2_valid;
    logic [WORD_W-1:0] s2_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2_data  <= '0;
        end else begin
            s2_valid <= s1_go && !s1_dec.store;
            s2_data  <= merged;
        end
    end

    assign ld_valid_o = s2_valid;
    assign ld_data_o  = s2_data;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
    import lsu_align_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid_i,
    input logic             mem_req_o,
    input logic             mem_we_o,
    input logic [LANES-1:0] mem_be_o,
    input logic             addr_err_o,
    input logic             ld_valid_o
);
    // R5: a refused access drives no lane and no request
    a_r5_fault_blocks_access: assert property (@(posedge clk) disable iff (rst)
        addr_err_o |-> (!mem_req_o && mem_be_o == '0));

    // R11: every memory request enables at least one lane
    a_r11_req_has_lanes: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> (mem_be_o != '0));

    // R12: an idle request cycle leads to neither access nor error
    a_r12_idle_is_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (!mem_req_o && !addr_err_o));

    // R13: a load request yields a result one cycle later
    a_r13_load_result_follows: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_we_o) |=> ld_valid_o);

    // R13: no result without a preceding load request
    a_r13_no_stray_result: assert property (@(posedge clk) disable iff (rst)
        !(mem_req_o && !mem_we_o) |=> !ld_valid_o);
endmodule

bind lsu_align_unit lsu_align_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_be_o    (mem_be_o),
    .addr_err_o  (addr_err_o),
    .ld_valid_o  (ld_valid_o)
);

// File: tb/lsu_align_unit_tb.sv
module lsu_align_unit_tb_top;
    localparam int ADDR_W = 32;
    localparam int OFFS_W = 16;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req_valid = 1'b0;
    logic [5:0]          req_opcode = '0;
    logic [ADDR_W-1:0]   req_base = '0;
    logic [OFFS_W-1:0]   req_offset = '0;
    logic [31:0]         req_sd = '0;
    logic [31:0]         req_old = '0;
    logic                mem_req, mem_we, addr_err, ld_valid;
    logic [ADDR_W-3:0]   mem_addr;
    logic [3:0]          mem_be;
    logic [31:0]         mem_wdata, mem_rdata, ld_data;

    always #2 clk = ~clk;   // 250 MHz

    lsu_align_unit #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) dut_i (
        .clk (clk), .rst (rst),
        .req_valid_i (req_valid), .req_opcode_i (req_opcode),
        .req_base_i (req_base), .req_offset_i (req_offset),
        .req_store_data_i (req_sd), .req_old_rd_i (req_old),
        .mem_req_o (mem_req), .mem_we_o (mem_we), .mem_addr_o (mem_addr),
        .mem_be_o (mem_be), .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata),
        .addr_err_o (addr_err), .ld_valid_o (ld_valid), .ld_data_o (ld_data)
    );

    // Memory model: 16 words, asynchronous read
    logic [31:0] mem [16];
    initial begin
        for (int i = 0; i < 16; i++)
            mem[i] = {8'(8'hF0 - i*3), 8'(8'h35 + i*5), 8'(8'hC1 + i*7), 8'(8'h0A + i*9)};
    end
    assign mem_rdata = mem[mem_addr[3:0]];

    typedef struct {
        int          due;
        string       tag;
        logic        req, we, err;
        logic [29:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
    } s1_exp_t;
    typedef struct {
        int          due;
        string       tag;
        logic [31:0] data;
    } ld_exp_t;

    s1_exp_t s1_q[$];
    ld_exp_t ld_q[$];
    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input logic [31:0] ea, input int k);
        logic [31:0] a;
        a = ea + k;
        return mem[a[5:2]][8*a[1:0] +: 8];
    endfunction

    function automatic string tag_of(input logic [5:0] op);
        case (op)
            6'b100000, 6'b100100: return "R2";
            6'b100001, 6'b100101: return "R3";
            6'b100011:            return "R4";
            6'b100010:            return "R6";
            6'b100110:            return "R7";
            6'b101000:            return "R8";
            6'b101001:            return "R9";
            6'b101011:            return "R10";
            default:              return "R12";
        endcase
    endfunction

    task automatic send(input logic [5:0] op, input logic [31:0] base,
                        input logic [15:0] off, input logic [31:0] sd,
                        input logic [31:0] old);
        s1_exp_t e;
        ld_exp_t l;
        logic [31:0] ea;
        int  a;
        bit  known, store, is_load, fault;
        @(negedge clk);
        req_valid = 1'b1; req_opcode = op; req_base = base;
        req_offset = off; req_sd = sd; req_old = old;
        ea = base + {{16{off[15]}}, off};
        a = int'(ea[1:0]);
        store = (op == 6'b101000 || op == 6'b101001 || op == 6'b101011);
        is_load = (op inside {6'b100000, 6'b100001, 6'b100010, 6'b100011,
                              6'b100100, 6'b100101, 6'b100110});
        known = store || is_load;
        fault = ((op == 6'b100001 || op == 6'b100101 || op == 6'b101001) && ea[0])
             || ((op == 6'b100011 || op == 6'b101011) && ea[1:0] != 2'b00);
        e.due = cyc + 1;
        e.tag = fault ? "R5" : tag_of(op);
        e.req = known && !fault;
        e.we  = store && !fault;
        e.err = known && fault;
        e.addr = ea[31:2];
        e.be = 4'b0000;
        e.wdata = 32'h0;
        if (e.req) begin
            case (op)
                6'b100000, 6'b100100, 6'b101000: e.be = 4'b0001 << a;
                6'b100001, 6'b100101, 6'b101001: e.be = 4'b0011 << a;
                6'b100011, 6'b101011:            e.be = 4'b1111;
                6'b100010: for (int k = 0; k <= a; k++) e.be[k] = 1'b1;
                6'b100110: for (int k = a; k < 4; k++) e.be[k] = 1'b1;
                default: ;
            endcase
        end
        case (op)
            6'b101000: e.wdata = {4{sd[7:0]}};
            6'b101001: e.wdata = {2{sd[15:0]}};
            6'b101011: e.wdata = sd;
            default: ;
        endcase
        s1_q.push_back(e);
        if (is_load && !fault) begin
            l.due = cyc + 2;
            l.tag = tag_of(op);
            l.data = old;
            case (op)
                6'b100000: l.data = {{24{mbyte(ea,0)}}[31:8] & 24'h0 | {24{mbyte(ea,0)[7]}}, mbyte(ea,0)};
                6'b100100: l.data = {24'h0, mbyte(ea,0)};
                6'b100001: l.data = {{16{mbyte(ea,1)[7]}}, mbyte(ea,1), mbyte(ea,0)};
                6'b100101: l.data = {16'h0, mbyte(ea,1), mbyte(ea,0)};
                6'b100011: l.data = {mbyte(ea,3), mbyte(ea,2), mbyte(ea,1), mbyte(ea,0)};
                6'b100010: for (int j = 0; j <= a; j++)
                               l.data[8*(3-j) +: 8] = mbyte(ea, -j);
                6'b100110: for (int j = 0; j <= 3 - a; j++)
                               l.data[8*j +: 8] = mbyte(ea, j);
                default: ;
            endcase
            ld_q.push_back(l);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        req_opcode = 6'b000000;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (s1_q.size() > 0 && s1_q[0].due == cyc) begin
                    s1_exp_t e;
                    e = s1_q.pop_front();
                    check(addr_err == e.err, e.err ? "R5" : e.tag, "addr_err", 32'(addr_err), 32'(e.err));
                    check(mem_req == e.req, e.tag, "mem_req", 32'(mem_req), 32'(e.req));
                    check(mem_we == e.we, e.tag, "mem_we", 32'(mem_we), 32'(e.we));
                    check(mem_be == e.be, e.we || !e.req ? e.tag : "R11", "mem_be", 32'(mem_be), 32'(e.be));
                    if (e.req)
                        check(mem_addr == e.addr, "R1", "mem_addr", 32'(mem_addr), 32'(e.addr));
                    if (e.we)
                        check(mem_wdata == e.wdata, e.tag, "mem_wdata", mem_wdata, e.wdata);
                end else begin
                    check(!mem_req && !addr_err, "R12", "idle request", 32'({mem_req, addr_err}), 32'h0);
                end
                if (ld_q.size() > 0 && ld_q[0].due == cyc) begin
                    ld_exp_t l;
                    l = ld_q.pop_front();
                    check(ld_valid == 1'b1, "R13", "ld_valid", 32'(ld_valid), 32'h1);
                    check(ld_data == l.data, l.tag, "ld_data", ld_data, l.data);
                end else begin
                    check(ld_valid == 1'b0, "R13", "stray ld_valid", 32'(ld_valid), 32'h0);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    localparam logic [5:0] OPS [10] = '{6'b100000, 6'b100100, 6'b100001, 6'b100101,
                                        6'b100011, 6'b100010, 6'b100110, 6'b101000,
                                        6'b101001, 6'b101011};

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R13: reset state
        check(!mem_req && !mem_we && !addr_err && !ld_valid && mem_be == 4'h0,
              "R13", "reset outputs", 32'({mem_req, mem_we, addr_err, ld_valid, mem_be}), 32'h0);
        rst = 1'b0;
        idle(2);
        // Every opcode at every lane, back to back; offsets alternate sign (R1)
        for (int o = 0; o < 10; o++) begin
            for (int ln = 0; ln < 4; ln++) begin
                logic [31:0] base;
                logic [15:0] off;
                base = 32'h0001_0100 + 32'(4 * ((o + ln) % 8)) + 32'(ln);
                off  = (o % 2 == 1) ? 16'hFFF8 : 16'h0014;
                send(OPS[o], base, off, 32'h8C7B_A596 ^ 32'(o * 32'h0101_0101 + ln),
                     32'hDEAD_BEEF ^ 32'(ln * 32'h1111_0000 + o));
            end
        end
        // R1: displacement that borrows through the upper address bits
        send(6'b100011, 32'h0000_0004, 16'h8000, 32'h0, 32'h0);
        // R12: unrecognised opcodes
        send(6'b001111, 32'h0001_0100, 16'h0000, 32'hFFFF_FFFF, 32'h0);
        send(6'b101111, 32'h0001_0101, 16'h0000, 32'hFFFF_FFFF, 32'h0);
        send(6'b000000, 32'h0001_0102, 16'h0000, 32'hFFFF_FFFF, 32'h0);
        idle(6);
        check(s1_q.size() == 0 && ld_q.size() == 0, "R13", "pending results",
              32'(s1_q.size() + ld_q.size()), 32'h0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule